// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the register side of an I2C master controller with byte FIFOs. A host reaches it through a simple word-addressed register port: a read or write strobe, a 5-bit word offset and 32-bit data. The block keeps the clock divider, control, command and target-address words and presents them to the separate transfer engine. It also holds one transmit and one receive byte FIFO, each 128 entries deep. The engine pops transmit bytes, pushes received bytes and pulses event lines. The block gathers those events into one write-one-to-clear status word and drives one interrupt line.

The receive high-water mark lives in the FIFO control word. It can be rewritten at any time, including during a transfer, so software can set it to the number of bytes still expected. The above-threshold status bit then follows the new value. The engine's events and the FIFO events share one fixed status layout. Software clears whatever it has handled by writing back the bits it read.

Top module: `i2cm_csr_front`

## Requirements
- R1: Words written at offset 0x0 (divider), 0x1 (control), 0x2 (command) and 0xA (target address) are stored whole and appear on `div_o`, `ctrl_o`, `cmd_o` and `taddr_o` after the write edge. Reading the same offsets returns them.
- R2: A write to offset 0x4 enqueues bits 7:0 into the 128-entry transmit FIFO. The engine receives the bytes in write order on `eng_tx_data_o` and removes one with `eng_tx_pop_i`. A write while the FIFO holds 128 bytes is ignored.
- R3: `eng_rx_push_i` enqueues `eng_rx_data_i` into the 128-entry receive FIFO, and a push while it is full is dropped. A read of offset 0x5 returns and removes the oldest byte in bits 7:0. A read of an empty receive FIFO returns 0 and changes nothing.
- R4: Offset 0xC reads the receive FIFO byte count in bits 7:0 and the transmit FIFO byte count in bits 15:8.
- R5: At offset 0x6, bits 15:8 are the receive high threshold and bits 7:0 the low threshold, and both read back. Writing a 1 in bit 16 empties both FIFOs.
- R6: The status word at 0xE has these bits: 25 address not acknowledged, 13 address acknowledged, 12 data done, 11 arbitration lost and 0 bus error. Each is set on the clock edge that samples the matching engine event pulse.
- R7: Writing 0xE clears every status bit written as 1 and keeps every bit written as 0. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R8: Status bit 2 is set while the receive count is at least the high threshold and the threshold is nonzero. It is set one edge after the condition first holds, including when the threshold is rewritten below the current count. A zero threshold never sets it.
- R9: Status bit 3 is set when an engine pop empties the transmit FIFO while `eng_wr_active_i` is high. It is not set when that input is low.
- R10: Status bit 4 is set when an engine push brings the receive FIFO to 128 bytes.
- R11: The interrupt enable word at 0xD stores and reads back only the bits defined in R6, R8, R9 and R10. `irq_o` is high exactly when some status bit and its enable bit are both 1.
- R12: Writing control with bit 8 set empties both FIFOs and clears the status word. The written control value is still stored.
- R13: Read data appears on `reg_rdata` the cycle after the `reg_rd` strobe. Offset 0x3 returns `eng_state_i`, and offsets with no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Word offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| div_o | output | 32 | Divider word to the engine |
| ctrl_o | output | 32 | Control word to the engine |
| cmd_o | output | 32 | Command word to the engine |
| taddr_o | output | 32 | Target address word to the engine |
| eng_state_i | input | 32 | Engine state returned at offset 0x3 |
| eng_tx_pop_i | input | 1 | Engine removes the transmit head byte |
| eng_tx_data_o | output | 8 | Transmit head byte (0 when empty) |
| eng_tx_empty_o | output | 1 | Transmit FIFO empty |
| eng_rx_push_i | input | 1 | Engine stores a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_wr_active_i | input | 1 | A write transfer is in progress |
| ev_nack_i | input | 1 | Address not acknowledged pulse |
| ev_addr_ack_i | input | 1 | Address acknowledged pulse |
| ev_done_i | input | 1 | Data done pulse |
| ev_arb_lost_i | input | 1 | Arbitration lost pulse |
| ev_bus_err_i | input | 1 | Bus error pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes, FIFO pushes and pops, and status set and clear all take effect on the edge that samples the strobe. Register reads come back one edge later, and the above-threshold bit is set one edge after the count or threshold change that causes it. The bench drives every strobe for one full cycle from a falling edge and samples outputs at the next falling edge. Before any read that must see the threshold bit, it inserts one idle cycle, so no read samples a status bit in the same cycle that bit is being set. The set-versus-clear race is driven on purpose, with the event pulse and the clearing write in the same cycle.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] OFS_DIV   = 5'h00;
  localparam logic [AW-1:0] OFS_CTRL  = 5'h01;
  localparam logic [AW-1:0] OFS_CMD   = 5'h02;
  localparam logic [AW-1:0] OFS_STATE = 5'h03;
  localparam logic [AW-1:0] OFS_TXW   = 5'h04;
  localparam logic [AW-1:0] OFS_RXR   = 5'h05;
  localparam logic [AW-1:0] OFS_FCTL  = 5'h06;
  localparam logic [AW-1:0] OFS_TADDR = 5'h0A;
  localparam logic [AW-1:0] OFS_WCNT  = 5'h0C;
  localparam logic [AW-1:0] OFS_IEN   = 5'h0D;
  localparam logic [AW-1:0] OFS_IST   = 5'h0E;

  // status bit positions (a software handler decodes these)
  localparam int unsigned B_NACK  = 25;
  localparam int unsigned B_AACK  = 13;
  localparam int unsigned B_DONE  = 12;
  localparam int unsigned B_ARB   = 11;
  localparam int unsigned B_FULL  = 4;
  localparam int unsigned B_EMPTY = 3;
  localparam int unsigned B_HIGH  = 2;
  localparam int unsigned B_BERR  = 0;

  localparam int unsigned B_CTRL_RST  = 8;
  localparam int unsigned B_FCTL_FLSH = 16;

  localparam logic [DW-1:0] ST_MASK =
    (32'd1 << B_NACK) | (32'd1 << B_AACK) | (32'd1 << B_DONE) | (32'd1 << B_ARB) |
    (32'd1 << B_FULL) | (32'd1 << B_EMPTY) | (32'd1 << B_HIGH) | (32'd1 << B_BERR);

  // write-one-to-clear with set taking priority
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] set,
                                             input logic [DW-1:0] clr);
    return ((cur & ~clr) | set) & ST_MASK;
  endfunction

  // high-water compare; a zero threshold disables it
  function automatic logic above_hi(input logic [15:0] cnt, input logic [15:0] hi);
    return (hi != 16'd0) && (cnt >= hi);
  endfunction
endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         push_ok,
  output logic                         pop_ok
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  assign count   = cnt_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2/R3: a push into a full FIFO leaves the count alone
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == CNT_W'(DEPTH)));
  // R3: a pop from an empty FIFO leaves it empty
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);
  // R5: flush empties the FIFO
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/i2cm_irq_stat.sv
module i2cm_irq_stat
  import i2cm_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic [DW-1:0] set_vec,
  input  logic          st_wr,
  input  logic [DW-1:0] st_wdata,
  input  logic          en_wr,
  input  logic [DW-1:0] en_wdata,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] en_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, en_q, clr_vec;

  assign clr_vec = st_wr ? st_wdata : '0;
  assign stat_o  = stat_q;
  assign en_o    = en_q;
  assign irq_o   = |(stat_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= clr_all ? '0 : w1c_next(stat_q, set_vec, clr_vec);
      if (en_wr) en_q <= en_wdata & ST_MASK;
    end
  end

  // R7: every incoming event is recorded even against a clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((stat_o & ($past(set_vec) & ST_MASK)) == ($past(set_vec) & ST_MASK)));
  // R7: bits not written with one and not reset stay as they were
  assert_w1c_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((stat_o & $past(stat_o) & ~$past(clr_vec)) == ($past(stat_o) & ~$past(clr_vec))));
  // R12: reset via control clears the status word
  assert_ctrl_rst_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (stat_o == '0));
endmodule

// File: rtl/i2cm_csr_front.sv
module i2cm_csr_front
  import i2cm_csr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [31:0]   div_o,
  output logic [31:0]   ctrl_o,
  output logic [31:0]   cmd_o,
  output logic [31:0]   taddr_o,
  input  logic [31:0]   eng_state_i,
  input  logic          eng_tx_pop_i,
  output logic [7:0]    eng_tx_data_o,
  output logic          eng_tx_empty_o,
  input  logic          eng_rx_push_i,
  input  logic [7:0]    eng_rx_data_i,
  input  logic          eng_wr_active_i,
  input  logic          ev_nack_i,
  input  logic          ev_addr_ack_i,
  input  logic          ev_done_i,
  input  logic          ev_arb_lost_i,
  input  logic          ev_bus_err_i,
  output logic          irq_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);

  logic [31:0] div_q, ctrl_q, cmd_q, taddr_q;
  logic [7:0]  hi_q, lo_q;
  logic [31:0] rdata_q, rd_mux;

  // named internal events
  logic wr_txw, wr_fctl, wr_ctrl, wr_ist, wr_ien, rd_rxr;
  logic ctrl_rst_wr, fifo_flush;
  logic tx_push_ok, tx_pop_ok, tx_full, tx_empty;
  logic rx_push_ok, rx_pop_ok, rx_full, rx_empty;
  logic tx_went_empty, rx_went_full, thr_hit;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [7:0] rx_head;
  logic [31:0] set_vec, stat, ien;

  assign wr_txw  = reg_wr && (reg_addr == OFS_TXW);
  assign wr_fctl = reg_wr && (reg_addr == OFS_FCTL);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_ist  = reg_wr && (reg_addr == OFS_IST);
  assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
  assign rd_rxr  = reg_rd && (reg_addr == OFS_RXR);

  assign ctrl_rst_wr = wr_ctrl && reg_wdata[B_CTRL_RST];
  assign fifo_flush  = ctrl_rst_wr || (wr_fctl && reg_wdata[B_FCTL_FLSH]);

  i2cm_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .push(wr_txw), .wdata(reg_wdata[7:0]),
    .pop(eng_tx_pop_i), .rdata(eng_tx_data_o),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

  i2cm_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .push(eng_rx_push_i), .wdata(eng_rx_data_i),
    .pop(rd_rxr), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

  assign eng_tx_empty_o = tx_empty;

  assign tx_went_empty = eng_wr_active_i && tx_pop_ok && !tx_push_ok &&
                         (tx_cnt == CNT_W'(1));
  assign rx_went_full  = rx_push_ok && !rx_pop_ok && (rx_cnt == CNT_W'(FIFO_DEPTH-1));
  assign thr_hit       = above_hi(16'(rx_cnt), 16'(hi_q));

  always_comb begin
    set_vec = '0;
    set_vec[B_NACK]  = ev_nack_i;
    set_vec[B_AACK]  = ev_addr_ack_i;
    set_vec[B_DONE]  = ev_done_i;
    set_vec[B_ARB]   = ev_arb_lost_i;
    set_vec[B_BERR]  = ev_bus_err_i;
    set_vec[B_FULL]  = rx_went_full;
    set_vec[B_EMPTY] = tx_went_empty;
    set_vec[B_HIGH]  = thr_hit;
  end

  i2cm_irq_stat u_stat (
    .clk(clk), .rst_n(rst_n), .clr_all(ctrl_rst_wr), .set_vec(set_vec),
    .st_wr(wr_ist), .st_wdata(reg_wdata),
    .en_wr(wr_ien), .en_wdata(reg_wdata),
    .stat_o(stat), .en_o(ien), .irq_o(irq_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; ctrl_q <= '0; cmd_q <= '0; taddr_q <= '0;
      hi_q  <= '0; lo_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_DIV:   div_q   <= reg_wdata;
        OFS_CTRL:  ctrl_q  <= reg_wdata;
        OFS_CMD:   cmd_q   <= reg_wdata;
        OFS_TADDR: taddr_q <= reg_wdata;
        OFS_FCTL: begin
          hi_q <= reg_wdata[15:8];
          lo_q <= reg_wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_DIV:   rd_mux = div_q;
      OFS_CTRL:  rd_mux = ctrl_q;
      OFS_CMD:   rd_mux = cmd_q;
      OFS_STATE: rd_mux = eng_state_i;
      OFS_RXR:   rd_mux = {24'd0, rx_head};
      OFS_FCTL:  rd_mux = {16'd0, hi_q, lo_q};
      OFS_TADDR: rd_mux = taddr_q;
      OFS_WCNT:  rd_mux = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
      OFS_IEN:   rd_mux = ien;
      OFS_IST:   rd_mux = stat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign div_o     = div_q;
  assign ctrl_o    = ctrl_q;
  assign cmd_o     = cmd_q;
  assign taddr_o   = taddr_q;

  // R8: threshold condition is recorded one edge later
  assert_high_water_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit && !ctrl_rst_wr) |=> stat[B_HIGH]);
  // R6: a done pulse lands in the status word
  assert_done_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_i && !ctrl_rst_wr) |=> stat[B_DONE]);
  // R9: no empty event without an active write transfer
  assert_empty_needs_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_wr_active_i && !stat[B_EMPTY]) |=> !stat[B_EMPTY]);
  // R10: receive FIFO reaching full is recorded
  assert_full_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_went_full && !ctrl_rst_wr) |=> stat[B_FULL]);
endmodule

// File: tb/i2cm_csr_front_tb.sv
module i2cm_csr_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] div_o, ctrl_o, cmd_o, taddr_o;
  logic [31:0] eng_state_i = '0;
  logic        eng_tx_pop_i = 1'b0;
  logic [7:0]  eng_tx_data_o;
  logic        eng_tx_empty_o;
  logic        eng_rx_push_i = 1'b0;
  logic [7:0]  eng_rx_data_i = '0;
  logic        eng_wr_active_i = 1'b0;
  logic        ev_nack_i = 1'b0, ev_addr_ack_i = 1'b0, ev_done_i = 1'b0;
  logic        ev_arb_lost_i = 1'b0, ev_bus_err_i = 1'b0;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] MASK_ALL = 32'h0200_381D;

  always #2.5 clk = ~clk;

  i2cm_csr_front u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_o(div_o), .ctrl_o(ctrl_o),
    .cmd_o(cmd_o), .taddr_o(taddr_o), .eng_state_i(eng_state_i),
    .eng_tx_pop_i(eng_tx_pop_i), .eng_tx_data_o(eng_tx_data_o),
    .eng_tx_empty_o(eng_tx_empty_o), .eng_rx_push_i(eng_rx_push_i),
    .eng_rx_data_i(eng_rx_data_i), .eng_wr_active_i(eng_wr_active_i),
    .ev_nack_i(ev_nack_i), .ev_addr_ack_i(ev_addr_ack_i), .ev_done_i(ev_done_i),
    .ev_arb_lost_i(ev_arb_lost_i), .ev_bus_err_i(ev_bus_err_i), .irq_o(irq_o));

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1; tick(); d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_data_i = b; eng_rx_push_i = 1'b1; tick(); eng_rx_push_i = 1'b0;
  endtask

  task automatic tx_pop(output logic [7:0] b);
    b = eng_tx_data_o; eng_tx_pop_i = 1'b1; tick(); eng_tx_pop_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R11 irq after reset", {31'd0, irq_o}, 32'd0);
    rd(5'h0E, d); check("R6 status after reset", d, 32'd0);
    rd(5'h0C, d); check("R4 counts after reset", d, 32'd0);
  endtask

  task automatic t_regs_r1();
    logic [31:0] d;
    wr(5'h00, 32'h0000_0013); wr(5'h01, 32'h0000_0050);
    wr(5'h02, 32'h0000_0090); wr(5'h0A, 32'h0000_00A5);
    check("R1 div_o", div_o, 32'h13);   check("R1 ctrl_o", ctrl_o, 32'h50);
    check("R1 cmd_o", cmd_o, 32'h90);   check("R1 taddr_o", taddr_o, 32'hA5);
    rd(5'h0A, d); check("R1 taddr readback", d, 32'hA5);
    rd(5'h00, d); check("R1 div readback", d, 32'h13);
  endtask

  task automatic t_read_r13();
    logic [31:0] d;
    eng_state_i = 32'hCAFE_0042;
    rd(5'h03, d); check("R13 engine state", d, 32'hCAFE_0042);
    rd(5'h1F, d); check("R13 unmapped reads zero", d, 32'd0);
    rd(5'h07, d); check("R13 hole reads zero", d, 32'd0);
  endtask

  task automatic t_rx_fifo();
    logic [31:0] d;
    int bad = 0;
    wr(5'h0E, 32'hFFFF_FFFF);
    for (int i = 0; i < 128; i++) rx_push(8'(i * 3 + 1));
    rx_push(8'hEE);
    rd(5'h0C, d); check("R4 rx count full", d, 32'h0000_0080);
    rd(5'h0E, d); check("R10 full bit", d & 32'h10, 32'h10);
    for (int i = 0; i < 128; i++) begin
      rd(5'h05, d);
      if (d !== {24'd0, 8'(i * 3 + 1)}) bad++;
    end
    check("R3 rx order with overflow dropped", bad, 0);
    rd(5'h05, d); check("R3 empty read zero", d, 32'd0);
    rd(5'h0C, d); check("R3 empty read leaves count", d, 32'd0);
  endtask

  task automatic t_tx_fifo();
    logic [31:0] d;
    logic [7:0]  b;
    int bad = 0;
    wr(5'h0E, 32'hFFFF_FFFF);
    for (int i = 0; i < 130; i++) wr(5'h04, 32'h0000_0100 | 32'(8'(i + 7)));
    rd(5'h0C, d); check("R4 tx count full", d, 32'h0000_8000);
    eng_wr_active_i = 1'b1;
    for (int i = 0; i < 128; i++) begin
      tx_pop(b);
      if (b !== 8'(i + 7)) bad++;
    end
    eng_wr_active_i = 1'b0;
    check("R2 tx order with overflow ignored", bad, 0);
    check("R2 tx empty flag", {31'd0, eng_tx_empty_o}, 32'd1);
    rd(5'h0E, d); check("R9 empty bit on active write", d & 32'h8, 32'h8);
    wr(5'h0E, 32'hFFFF_FFFF);
    wr(5'h04, 32'h0000_0055);
    tx_pop(b);
    rd(5'h0E, d); check("R9 no empty bit when inactive", d & 32'h8, 32'd0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(5'h06, 32'h0001_0402);
    rd(5'h06, d); check("R5 threshold readback", d, 32'h0000_0402);
    wr(5'h0E, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) rx_push(8'(i));
    tick();
    rd(5'h0E, d); check("R8 below threshold", d & 32'h4, 32'd0);
    rx_push(8'h33); tick();
    rd(5'h0E, d); check("R8 at threshold", d & 32'h4, 32'h4);
    wr(5'h06, 32'h0001_0000);
    rd(5'h0C, d); check("R5 flush empties both", d, 32'd0);
    wr(5'h0E, 32'hFFFF_FFFF);
    rx_push(8'h1); rx_push(8'h2); tick();
    rd(5'h0E, d); check("R8 zero threshold never sets", d & 32'h4, 32'd0);
    wr(5'h06, 32'h0000_0100); tick();
    rd(5'h0E, d); check("R8 lowered threshold tracks", d & 32'h4, 32'h4);
    wr(5'h06, 32'h0001_0000);
    wr(5'h0E, 32'hFFFF_FFFF);
  endtask

  task automatic t_events();
    logic [31:0] d;
    wr(5'h0D, 32'hFFFF_FFFF);
    rd(5'h0D, d); check("R11 enable holds defined bits only", d, MASK_ALL);
    wr(5'h0E, 32'hFFFF_FFFF);
    ev_nack_i = 1; ev_addr_ack_i = 1; ev_done_i = 1; ev_arb_lost_i = 1; ev_bus_err_i = 1;
    tick();
    ev_nack_i = 0; ev_addr_ack_i = 0; ev_done_i = 0; ev_arb_lost_i = 0; ev_bus_err_i = 0;
    rd(5'h0E, d); check("R6 event bit layout", d, 32'h0200_3801);
    check("R11 irq with enabled status", {31'd0, irq_o}, 32'd1);
    wr(5'h0E, 32'h0200_1000);
    rd(5'h0E, d); check("R7 w1c partial clear", d, 32'h0000_2801);
    reg_addr = 5'h0E; reg_wdata = 32'h0000_1000; reg_wr = 1'b1; ev_done_i = 1'b1;
    tick(); reg_wr = 1'b0; ev_done_i = 1'b0;
    rd(5'h0E, d); check("R7 set wins over clear", d, 32'h0000_3801);
    wr(5'h0D, 32'h0000_1000);
    wr(5'h0E, 32'h0000_1000);
    check("R11 irq low when enabled bit clear", {31'd0, irq_o}, 32'd0);
    ev_done_i = 1'b1; tick(); ev_done_i = 1'b0;
    check("R11 irq on enabled done", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_ctrl_reset();
    logic [31:0] d;
    rx_push(8'h9); wr(5'h04, 32'h11);
    wr(5'h01, 32'h0000_0150);
    rd(5'h0C, d);  check("R12 fifos emptied", d, 32'd0);
    rd(5'h0E, d);  check("R12 status cleared", d, 32'd0);
    check("R12 control stored", ctrl_o, 32'h0000_0150);
    check("R12 irq low", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs_r1();
    t_read_r13();
    t_rx_fifo();
    t_tx_fifo();
    t_threshold();
    t_events();
    t_ctrl_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule